// File: doc/BRIEF.md
# Cascaded Switch-Register Serial Loader

This block sits on the controlling side of a chain of serially loaded analog-switch control registers. Each device in the chain holds a 16-bit shift register, a 16-bit latch and a serial output that feeds the next device. A single start pulse hands the block one wide pattern that covers every device. The block then produces the serial data line and the shift clock. It keeps the latch-hold line high while it shifts, and afterwards drops that line low for a pulse of guaranteed length, so that every switch takes its new state at the same moment.

A separate clear request makes the block drive a clear pulse of guaranteed length, which turns every switch off. All timing is counted in system-clock cycles and set by parameters: the shift-clock half period, the extra wait between the final rising shift-clock edge and the latch pulse, the latch pulse width and the clear width. A busy level and a one-cycle done pulse tell the requester when a new request may be issued.

Top module: `sw_chain_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, sclk_o=0, hold_o=1, clear_o=0, busy_o=0, done_o=0 and sdata_o=0.
- R2: A start request in idle shifts out N_DEV*16 bits, starting at pattern_i bit N_DEV*16-1 and ending at bit 0. A receiving chain that shifts sdata_o in at its bit 0 on each rising sclk_o therefore holds, in device d (device 0 nearest the loader), pattern_i[16*d+15:16*d], with switch k at bit k. The chain's latch then holds that value.
- R3: During a load, sclk_o stays high for exactly HALF_CNT cycles and stays low for exactly HALF_CNT cycles between rising edges. Each load produces exactly N_DEV*16 rising edges.
- R4: sdata_o changes only together with a falling sclk_o edge or at the start of a load, never while sclk_o is high. It is stable for at least HALF_CNT cycles before each rising sclk_o edge.
- R5: hold_o stays high during every sclk_o high phase. It falls exactly HALF_CNT+SETUP_CNT cycles after the last rising sclk_o edge of a load.
- R6: Each load makes exactly one low pulse on hold_o, and that pulse lasts exactly LE_CNT cycles.
- R7: A clear request in idle drives clear_o high for exactly CLR_CNT cycles, with no sclk_o edge and no hold_o pulse. The switches modelled behind the latch then read all zero.
- R8: When start and clear requests arrive in the same idle cycle, the clear is carried out and the start is dropped.
- R9: Start and clear requests that arrive while busy_o is high are ignored: the load in progress completes with its original pattern and no clear pulse appears.
- R10: busy_o rises in the cycle after an accepted request. done_o is high for exactly one cycle, which is the last cycle with busy_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load request, sampled in idle only |
| clear_req_i | input | 1 | Clear request, sampled in idle only; has priority over start |
| pattern_i | input | N_DEV*16 | Switch pattern; bits 16*d+15..16*d belong to device d |
| busy_o | output | 1 | High while a request is in progress |
| done_o | output | 1 | One-cycle pulse when a request completes |
| sdata_o | output | 1 | Serial data to the first device of the chain |
| sclk_o | output | 1 | Shift clock; the devices sample data on its rising edge |
| hold_o | output | 1 | Latch hold; high keeps the switches, a low pulse transfers the chain |
| clear_o | output | 1 | Clear pulse that turns every switch off |

## Verification
If the bit counter or the shifter goes wrong, the final switch pattern in the receiving-chain model comes out rotated or corrupted. That shows up at the end of the very load in which it happens, together with a rising-edge count that is not N_DEV*16. If the shared interval timer is mis-loaded, a phase length changes. The bench measures every sclk_o phase, the setup gap and the hold_o and clear_o pulse widths as each pulse ends, so such a fault is reported within a single shift-clock period. A fault in state sequencing shows up as a request that is accepted while busy, or as a done pulse that is not at the end of busy.

// File: rtl/sw_loader_pkg.sv
package sw_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SHIFT = 3'd1,
    ST_SETUP = 3'd2,
    ST_LATCH = 3'd3,
    ST_DONE  = 3'd4,
    ST_CLEAR = 3'd5
  } ld_state_t;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sw_interval_timer.sv
// Down-counter shared by every timed phase. After a load with value V,
// expired_o reads high V-1 cycles later, so the phase that loaded it
// lasts exactly V cycles.
module sw_interval_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sw_shift_out.sv
// Parallel-load, MSB-first serialiser. Its top bit drives the data line
// straight from a flop.
module sw_shift_out #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic         msb_o
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= data_i;
    end else if (shift_i) begin
      sr_q <= {sr_q[W-2:0], 1'b0};
    end
  end

  assign msb_o = sr_q[W-1];

endmodule

// File: rtl/sw_chain_loader.sv
module sw_chain_loader
  import sw_loader_pkg::*;
#(
  parameter int N_DEV     = 2,
  parameter int DEV_BITS  = 16,
  parameter int HALF_CNT  = 2,
  parameter int SETUP_CNT = 2,
  parameter int LE_CNT    = 2,
  parameter int CLR_CNT   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic                      clear_req_i,
  input  logic [N_DEV*DEV_BITS-1:0] pattern_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      sdata_o,
  output logic                      sclk_o,
  output logic                      hold_o,
  output logic                      clear_o
);

  localparam int TOTAL = N_DEV * DEV_BITS;
  localparam int BCW   = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam int MAXC  = max_of4(HALF_CNT, SETUP_CNT, LE_CNT, CLR_CNT);
  localparam int TCW   = $clog2(MAXC + 1);

  localparam logic [BCW-1:0] LAST_BIT = BCW'(TOTAL - 1);
  localparam logic [TCW-1:0] HALF_V   = TCW'(HALF_CNT);
  localparam logic [TCW-1:0] SETUP_V  = TCW'(SETUP_CNT);
  localparam logic [TCW-1:0] LE_V     = TCW'(LE_CNT);
  localparam logic [TCW-1:0] CLR_V    = TCW'(CLR_CNT);

  ld_state_t      state_q, nxt_state;
  logic [BCW-1:0] bit_q, nxt_bit;
  logic           sclk_q, nxt_sclk;
  logic           hold_q, nxt_hold;
  logic           clr_q, nxt_clr;
  logic           done_q, nxt_done;
  logic           busy_q;

  logic           tmr_load, tmr_exp;
  logic [TCW-1:0] tmr_val;
  logic           sh_load, sh_shift;

  sw_interval_timer #(.CW(TCW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load_i   (tmr_load),
    .val_i    (tmr_val),
    .expired_o(tmr_exp)
  );

  sw_shift_out #(.W(TOTAL)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load_i (sh_load),
    .shift_i(sh_shift),
    .data_i (pattern_i),
    .msb_o  (sdata_o)
  );

  always_comb begin
    nxt_state = state_q;
    nxt_bit   = bit_q;
    nxt_sclk  = sclk_q;
    nxt_hold  = hold_q;
    nxt_clr   = clr_q;
    nxt_done  = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = HALF_V;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (clear_req_i) begin
          nxt_state = ST_CLEAR;
          nxt_clr   = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = CLR_V;
        end else if (start_i) begin
          nxt_state = ST_SHIFT;
          nxt_bit   = '0;
          sh_load   = 1'b1;
          tmr_load  = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (!sclk_q) begin
            nxt_sclk = 1'b1;
          end else begin
            nxt_sclk = 1'b0;
            if (bit_q == LAST_BIT) begin
              nxt_state = ST_SETUP;
              tmr_val   = SETUP_V;
            end else begin
              sh_shift = 1'b1;
              nxt_bit  = bit_q + 1'b1;
            end
          end
        end
      end
      ST_SETUP: begin
        if (tmr_exp) begin
          nxt_state = ST_LATCH;
          nxt_hold  = 1'b0;
          tmr_load  = 1'b1;
          tmr_val   = LE_V;
        end
      end
      ST_LATCH: begin
        if (tmr_exp) begin
          nxt_state = ST_DONE;
          nxt_hold  = 1'b1;
          nxt_done  = 1'b1;
        end
      end
      ST_CLEAR: begin
        if (tmr_exp) begin
          nxt_state = ST_DONE;
          nxt_clr   = 1'b0;
          nxt_done  = 1'b1;
        end
      end
      ST_DONE:  nxt_state = ST_IDLE;
      default:  nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      hold_q  <= 1'b1;
      clr_q   <= 1'b0;
      done_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= nxt_state;
      bit_q   <= nxt_bit;
      sclk_q  <= nxt_sclk;
      hold_q  <= nxt_hold;
      clr_q   <= nxt_clr;
      done_q  <= nxt_done;
      busy_q  <= (nxt_state != ST_IDLE);
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign sclk_o  = sclk_q;
  assign hold_o  = hold_q;
  assign clear_o = clr_q;

endmodule

// File: rtl/sw_chain_loader_chk.sv
module sw_chain_loader_chk #(
  parameter int HALF_CNT = 2,
  parameter int LE_CNT   = 2,
  parameter int CLR_CNT  = 3
) (
  input logic clk,
  input logic rst,
  input logic busy_o,
  input logic done_o,
  input logic sdata_o,
  input logic sclk_o,
  input logic hold_o,
  input logic clear_o
);

  logic [31:0] low_run_q, clr_run_q, hi_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run_q <= '0;
      clr_run_q <= '0;
      hi_run_q  <= '0;
    end else begin
      low_run_q <= hold_o  ? 32'd0 : low_run_q + 32'd1;
      clr_run_q <= clear_o ? clr_run_q + 32'd1 : 32'd0;
      hi_run_q  <= sclk_o  ? hi_run_q + 32'd1 : 32'd0;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!sclk_o && hold_o && !clear_o && !busy_o && !done_o && !sdata_o));

  // R4
  data_stable_chk: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> $stable(sdata_o));

  // R3
  sclk_high_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> (hi_run_q == HALF_CNT));

  // R5
  hold_during_clock_chk: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> hold_o);

  // R6
  latch_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_o) |-> (low_run_q == LE_CNT));

  // R7
  clear_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(clear_o) |-> (clr_run_q == CLR_CNT));

  // R7
  clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    clear_o |-> (!sclk_o && hold_o));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_o ##1 (!done_o && !busy_o));

  // R9
  activity_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_o || !hold_o || clear_o) |-> busy_o);

endmodule

bind sw_chain_loader sw_chain_loader_chk #(
  .HALF_CNT(HALF_CNT),
  .LE_CNT  (LE_CNT),
  .CLR_CNT (CLR_CNT)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy_o (busy_o),
  .done_o (done_o),
  .sdata_o(sdata_o),
  .sclk_o (sclk_o),
  .hold_o (hold_o),
  .clear_o(clear_o)
);

// File: tb/test_sw_chain_loader.sv
module test_sw_chain_loader;

  localparam int N_DEV = 3;
  localparam int DBITS = 16;
  localparam int TOTAL = N_DEV * DBITS;
  localparam int HALF  = 2;
  localparam int SETUP = 3;
  localparam int LEW   = 4;
  localparam int CLRW  = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic             clear_req_i = 1'b0;
  logic [TOTAL-1:0] pattern_i = '0;
  logic busy_o, done_o, sdata_o, sclk_o, hold_o, clear_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  sw_chain_loader #(
    .N_DEV(N_DEV), .DEV_BITS(DBITS), .HALF_CNT(HALF),
    .SETUP_CNT(SETUP), .LE_CNT(LEW), .CLR_CNT(CLRW)
  ) i_sw_chain_loader (
    .clk(clk), .rst(rst), .start_i(start_i), .clear_req_i(clear_req_i),
    .pattern_i(pattern_i), .busy_o(busy_o), .done_o(done_o),
    .sdata_o(sdata_o), .sclk_o(sclk_o), .hold_o(hold_o), .clear_o(clear_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DBITS-1:0] dev_word(input logic [TOTAL-1:0] v, input int d);
    return v[d*DBITS +: DBITS];
  endfunction

  // Model of the cascaded receiving registers and their latches
  logic [TOTAL-1:0] chain_m = '0;
  logic [TOTAL-1:0] latch_m = '0;
  int rises = 0, le_pulses = 0, clr_pulses = 0;
  logic p_sclk = 1'b0, p_hold = 1'b1, p_clr = 1'b0, p_sdata = 1'b0;
  logic p_busy = 1'b0, p_done = 1'b0;
  int hi_len = 0, lo_len = 0, le_len = 0, cl_len = 0, data_age = 0, rise_age = 0;

  always @(negedge clk) begin
    if (!rst) begin
      data_age++;
      rise_age++;
      if (sdata_o !== p_sdata) begin
        if (sclk_o) check("R4 data changed while clock high", 1, 0);
        data_age = 0;
      end
      if (busy_o && !p_busy) data_age = 0;
      if (sclk_o) hi_len++; else lo_len++;
      if (sclk_o && !p_sclk) begin
        check("R4 setup before rising edge", 64'(data_age >= HALF), 1);
        if (rises > 0) check("R3 low phase width", 64'(lo_len), 64'(HALF));
        check("R5 hold high at rising edge", 64'(hold_o), 1);
        chain_m = {chain_m[TOTAL-2:0], sdata_o};
        rises++;
        lo_len = 0;
        rise_age = 0;
      end
      if (!sclk_o && p_sclk) begin
        check("R3 high phase width", 64'(hi_len), 64'(HALF));
        hi_len = 0;
      end
      if (!hold_o) le_len++;
      if (!hold_o && p_hold)
        check("R5 last rise to latch fall", 64'(rise_age), 64'(HALF + SETUP));
      if (!hold_o) latch_m = chain_m;
      if (hold_o && !p_hold) begin
        check("R6 latch pulse width", 64'(le_len), 64'(LEW));
        le_len = 0;
        le_pulses++;
      end
      if (clear_o) begin
        cl_len++;
        latch_m = '0;
        if (sclk_o) check("R7 clock during clear", 1, 0);
      end
      if (!clear_o && p_clr) begin
        check("R7 clear width", 64'(cl_len), 64'(CLRW));
        cl_len = 0;
        clr_pulses++;
      end
      if (done_o && !busy_o) check("R10 done without busy", 1, 0);
      if (p_done && (done_o || busy_o)) check("R10 done/busy after done", {done_o, busy_o}, 0);
    end
    p_sclk = sclk_o; p_hold = hold_o; p_clr = clear_o; p_sdata = sdata_o;
    p_busy = busy_o; p_done = done_o;
  end

  task automatic clear_stats();
    rises = 0; le_pulses = 0; clr_pulses = 0;
  endtask

  task automatic request(input logic [TOTAL-1:0] pat, input logic st, input logic cl,
                         input logic expect_busy);
    @(negedge clk);
    pattern_i   = pat;
    start_i     = st;
    clear_req_i = cl;
    @(negedge clk);
    start_i     = 1'b0;
    clear_req_i = 1'b0;
    if (expect_busy) check("R10 busy after accepted request", 64'(busy_o), 1);
  endtask

  task automatic wait_done();
    while (done_o !== 1'b1) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_load(input logic [TOTAL-1:0] pat, input string tag);
    for (int d = 0; d < N_DEV; d++)
      check({"R2 device word ", tag}, 64'(dev_word(latch_m, d)), 64'(dev_word(pat, d)));
    check({"R3 rising edge count ", tag}, 64'(rises), 64'(TOTAL));
    check({"R6 latch pulse count ", tag}, 64'(le_pulses), 1);
    check({"R9 no clear pulse ", tag}, 64'(clr_pulses), 0);
  endtask

  task automatic do_load(input logic [TOTAL-1:0] pat, input string tag);
    clear_stats();
    request(pat, 1'b1, 1'b0, 1'b1);
    wait_done();
    expect_load(pat, tag);
  endtask

  function automatic logic [TOTAL-1:0] rand_pat();
    logic [TOTAL-1:0] v;
    for (int i = 0; i < TOTAL; i += 32) v = {v, $urandom()};
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [TOTAL-1:0] pa, pb;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    check("R1 reset sclk", 64'(sclk_o), 0);
    check("R1 reset hold", 64'(hold_o), 1);
    check("R1 reset clear/busy/done/data", {clear_o, busy_o, done_o, sdata_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", {sclk_o, hold_o, clear_o, busy_o, done_o}, 5'b01000);

    // Directed corner patterns (R2)
    do_load('0, "zeros");
    do_load('1, "ones");
    pa = '0;
    for (int i = 0; i < TOTAL; i += 2) pa[i] = 1'b1;
    do_load(pa, "alternating");
    pa = '0;
    pa[TOTAL-1] = 1'b1;
    pa[0] = 1'b1;
    do_load(pa, "end bits");

    // Random patterns (R2)
    for (int n = 0; n < 6; n++) do_load(rand_pat(), "random");

    // R7: clear from idle
    clear_stats();
    request('1, 1'b0, 1'b1, 1'b1);
    wait_done();
    check("R7 switches off after clear", 64'(latch_m), 0);
    check("R7 no rising edge during clear", 64'(rises), 0);
    check("R7 no latch pulse during clear", 64'(le_pulses), 0);
    check("R7 one clear pulse", 64'(clr_pulses), 1);

    // R8: simultaneous start and clear
    do_load(rand_pat() | 1, "before priority");
    clear_stats();
    request('1, 1'b1, 1'b1, 1'b1);
    wait_done();
    check("R8 clear wins: switches off", 64'(latch_m), 0);
    check("R8 clear wins: no shifting", 64'(rises), 0);
    check("R8 clear wins: one clear pulse", 64'(clr_pulses), 1);

    // R9: requests during a load are ignored
    pa = rand_pat();
    pb = ~pa;
    clear_stats();
    request(pa, 1'b1, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    request(pb, 1'b1, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    request(pb, 1'b0, 1'b1, 1'b0);
    check("R9 still busy after ignored clear", 64'(busy_o), 1);
    wait_done();
    expect_load(pa, "busy requests");

    // R10: back to idle, nothing pending
    repeat (5) @(negedge clk);
    check("R10 idle after all requests", {busy_o, done_o, sclk_o, clear_o}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule